// File: doc/BRIEF.md
# Windowed Temporal Event Monitor

This block watches a small group of Boolean signals and raises a single flag in every cycle where a fixed conjunctive pattern is present across a sliding time window. The pattern can place a literal on any input at any delay from 0 (the value on the port in the current cycle) to `DEPTH` (the value seen `DEPTH` cycles ago). Each literal can require the signal to be high, require it to be low, or leave it unconstrained. The block is meant to sit in front of trigger or latching logic that has to react to short input sequences, such as a limit switch going high one cycle after a sensor drops.

Each input keeps a history line of `DEPTH` slots. Every slot carries two bits: a "seen" flag and the sampled value. A synchronous reset clears every seen flag. From then on the slots fill one position per clock. A small fill controller has two states, FILL and LIVE. Reset sends it to FILL. In FILL it counts clock edges and takes the FILL→LIVE transition on the edge that completes `DEPTH` samples. LIVE holds until the next reset, which is the LIVE→FILL transition. The output can be high only in LIVE, so logic downstream never acts on a partly filled window.

The match is combinational over the current inputs and the stored history, so a completed pattern shows on the output in the same cycle as its newest literal. When `DEPTH` is 0, no storage is built and the block reduces to a gate-level match on the current inputs.

Top module: `temporal_window_monitor`

## Requirements
- R1: `PATTERN` holds two bits for each literal. The literal for input i at delay d has index e = d*NUM_IN + i. Bit 2e+1 is its care flag and bit 2e is its required level (1 = high, 0 = low). `hit` can be high only if every literal with its care flag set matches.
- R2: After a cycle with `rst` high, every history slot of every input is marked not-yet-seen, and no stale history can produce a match.
- R3: On each clock edge with `rst` low, history slot 1 takes the current input and slot k+1 takes the previous content of slot k.
- R4: `hit` is low in the cycle after reset is released and during the following `DEPTH`-1 cycles, i.e. until `DEPTH` samples have been recorded.
- R5: Once the window is full, `hit` equals the conjunction of all cared literals, evaluated on the current `sig_in` (delay 0) and the stored history (delays 1..`DEPTH`), in the same cycle.
- R6: A literal whose care flag is clear never blocks a match: toggling that input at that delay does not change `hit`.
- R7: With `NUM_IN`=2 and `DEPTH`=2, the pattern is input 0 low at delay 2, input 0 high and input 1 high at delay 1, and input 1 low at delay 0. After a reset, the samples {in1,in0} = 00, 11, 01 give `hit` = 0, 0, 1.
- R8: With `DEPTH`=0 there is no state, and `hit` follows the current inputs combinationally from the first cycle, even while `rst` is high.
- R9: If any slot that the pattern cares about has not yet been seen, `hit` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sig_in | input | NUM_IN | Monitored Boolean signals |
| hit | output | 1 | High while the pattern is present across the window |

## Verification
The monitor is driven with the default worked sequence, which shows that the delay alignment of each literal is correct and that the two fill cycles are blanked. A sequence that changes only an unconstrained literal shows whether don't-care positions are really ignored. A reset in the middle of a matching stream shows whether the history is cleared rather than reused. A long pseudo-random stream exercises both polarities at every delay and compares each cycle against a queue-based reference model. A second instance with no history shows that the zero-depth variant matches from the first cycle.

// File: rtl/twm_pkg.sv
package twm_pkg;

    // One history position: whether it has been observed, and its level.
    typedef struct packed {
        logic seen;
        logic val;
    } slot_t;

    typedef enum logic [0:0] {
        FILL = 1'b0,
        LIVE = 1'b1
    } fill_state_e;

    // Bit offset of the care flag for literal (delay d, input i).
    function automatic int care_bit(input int d, input int i, input int n_in);
        return 2 * (d * n_in + i) + 1;
    endfunction

    // Bit offset of the required level for literal (delay d, input i).
    function automatic int pol_bit(input int d, input int i, input int n_in);
        return 2 * (d * n_in + i);
    endfunction

endpackage

// File: rtl/twm_history.sv
module twm_history
    import twm_pkg::*;
#(
    parameter int NUM_IN = 2,
    parameter int DEPTH  = 2
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NUM_IN-1:0]              cur,
    output slot_t [DEPTH:0][NUM_IN-1:0]    win
);

    // Delay 0 is always the live input and is always known.
    for (genvar i = 0; i < NUM_IN; i++) begin : g_now
        assign win[0][i] = '{seen: 1'b1, val: cur[i]};
    end

    if (DEPTH > 0) begin : g_store
        slot_t [DEPTH:1][NUM_IN-1:0] hist_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int k = 1; k <= DEPTH; k++) begin
                    for (int i = 0; i < NUM_IN; i++) begin
                        hist_q[k][i] <= '{seen: 1'b0, val: 1'b0};
                    end
                end
            end else begin
                hist_q[1] <= win[0];
                for (int k = 2; k <= DEPTH; k++) begin
                    hist_q[k] <= hist_q[k-1];
                end
            end
        end

        for (genvar k = 1; k <= DEPTH; k++) begin : g_out
            assign win[k] = hist_q[k];
        end

        for (genvar i = 0; i < NUM_IN; i++) begin : g_chk
            // R3: the first slot records the previous input
            a_r3_head_records: assert property (@(posedge clk) disable iff (rst)
                !$past(rst) |-> (hist_q[1][i].seen && hist_q[1][i].val == $past(cur[i])));
            // R2: reset leaves the first slot unknown
            a_r2_reset_unknown: assert property (@(posedge clk) disable iff (rst)
                $past(rst) |-> !hist_q[1][i].seen);
        end
    end

endmodule

// File: rtl/twm_fill_fsm.sv
module twm_fill_fsm
    import twm_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    output logic full
);

    if (DEPTH == 0) begin : g_none
        assign full = 1'b1;
    end else begin : g_fsm
        localparam int CW = (DEPTH < 2) ? 1 : $clog2(DEPTH);
        localparam logic [CW-1:0] LAST = CW'(DEPTH - 1);

        fill_state_e state_q, state_d;
        logic [CW-1:0] cnt_q, cnt_d;

        always_ff @(posedge clk) begin
            if (rst) begin
                state_q <= FILL;
                cnt_q   <= '0;
            end else begin
                state_q <= state_d;
                cnt_q   <= cnt_d;
            end
        end

        always_comb begin
            state_d = state_q;
            cnt_d   = cnt_q;
            unique case (state_q)
                FILL: begin
                    if (cnt_q == LAST) begin
                        state_d = LIVE;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                LIVE: begin
                    state_d = LIVE;
                end
                default: state_d = FILL;
            endcase
        end

        always_comb begin
            unique case (state_q)
                FILL:    full = 1'b0;
                LIVE:    full = 1'b1;
                default: full = 1'b0;
            endcase
        end

        // R4: once live, the window stays full until reset
        a_r4_live_sticky: assert property (@(posedge clk) disable iff (rst)
            (state_q == LIVE) |=> (state_q == LIVE));
        // R4: the counter never runs past the window length
        a_r4_cnt_bound: assert property (@(posedge clk) disable iff (rst)
            cnt_q <= LAST);
    end

endmodule

// File: rtl/twm_match.sv
module twm_match
    import twm_pkg::*;
#(
    parameter int                          NUM_IN  = 2,
    parameter int                          DEPTH   = 2,
    parameter logic [2*NUM_IN*(DEPTH+1)-1:0] PATTERN = '0
) (
    input  slot_t [DEPTH:0][NUM_IN-1:0] win,
    output logic                        match
);

    localparam int LITS = NUM_IN * (DEPTH + 1);

    logic [LITS-1:0] lit_ok;

    for (genvar d = 0; d <= DEPTH; d++) begin : g_delay
        for (genvar i = 0; i < NUM_IN; i++) begin : g_in
            localparam logic CARE = PATTERN[care_bit(d, i, NUM_IN)];
            localparam logic POL  = PATTERN[pol_bit(d, i, NUM_IN)];
            // An unknown slot fails a cared literal; a don't-care literal passes.
            assign lit_ok[d*NUM_IN + i] =
                !CARE || (win[d][i].seen && (win[d][i].val == POL));
        end
    end

    assign match = &lit_ok;

endmodule

// File: rtl/temporal_window_monitor.sv
module temporal_window_monitor
    import twm_pkg::*;
#(
    parameter int                          NUM_IN  = 2,
    parameter int                          DEPTH   = 2,
    parameter logic [2*NUM_IN*(DEPTH+1)-1:0] PATTERN = 12'b00_10_11_11_10_00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_IN-1:0] sig_in,
    output logic              hit
);

    slot_t [DEPTH:0][NUM_IN-1:0] win;
    logic                        full;
    logic                        match;

    twm_history #(
        .NUM_IN (NUM_IN),
        .DEPTH  (DEPTH)
    ) u_history (
        .clk (clk),
        .rst (rst),
        .cur (sig_in),
        .win (win)
    );

    twm_fill_fsm #(
        .DEPTH (DEPTH)
    ) u_fill (
        .clk  (clk),
        .rst  (rst),
        .full (full)
    );

    twm_match #(
        .NUM_IN  (NUM_IN),
        .DEPTH   (DEPTH),
        .PATTERN (PATTERN)
    ) u_match (
        .win   (win),
        .match (match)
    );

    assign hit = full && match;

    if (DEPTH > 0) begin : g_chk
        logic [NUM_IN-1:0] oldest_seen;
        for (genvar i = 0; i < NUM_IN; i++) begin : g_old
            assign oldest_seen[i] = win[DEPTH][i].seen;
        end

        // R4: the first cycle after reset never reports a hit
        a_r4_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> !hit);
        // R9: the controller declares the window full only when the oldest slots are known
        a_r9_full_means_seen: assert property (@(posedge clk) disable iff (rst)
            full |-> (&oldest_seen));
        // R9: a hit never coexists with an unobserved oldest slot
        a_r9_unknown_blocks: assert property (@(posedge clk) disable iff (rst)
            !(&oldest_seen) |-> !hit);
    end

endmodule

// File: tb/tb_temporal_window_monitor.sv
`timescale 1ns/1ps
module tb_temporal_window_monitor;

    localparam int W = 2;
    localparam int N = 2;
    localparam logic [2*W*(N+1)-1:0] PAT  = 12'b00_10_11_11_10_00;
    localparam logic [2*W-1:0]       PAT0 = 4'b00_11;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] sig_in = '0;
    logic         hit;
    logic         hit0;

    int n_cmp  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [W-1:0] hist[$];

    always #10 clk = ~clk;

    temporal_window_monitor #(.NUM_IN(W), .DEPTH(N), .PATTERN(PAT)) dut (
        .clk (clk), .rst (rst), .sig_in (sig_in), .hit (hit)
    );

    temporal_window_monitor #(.NUM_IN(W), .DEPTH(0), .PATTERN(PAT0)) dut_comb (
        .clk (clk), .rst (rst), .sig_in (sig_in), .hit (hit0)
    );

    function automatic logic model_hit(input logic [W-1:0] cur);
        if (hist.size() < N) return 1'b0;
        for (int d = 0; d <= N; d++) begin
            for (int i = 0; i < W; i++) begin
                int e = d * W + i;
                logic v;
                if (PAT[2*e+1]) begin
                    v = (d == 0) ? cur[i] : hist[d-1][i];
                    if (v != PAT[2*e]) return 1'b0;
                end
            end
        end
        return 1'b1;
    endfunction

    task automatic step(input logic r, input logic [W-1:0] v, input string tag);
        logic exp_h, exp_0;
        @(negedge clk);
        rst = r;
        sig_in = v;
        #2;
        exp_h = model_hit(v);
        exp_0 = (v[0] == PAT0[0]);
        n_cmp++;
        if (hit !== exp_h) begin
            n_fail++;
            $display("FAIL %s: hit=%0b expected %0b (in=%b)", tag, hit, exp_h, v);
        end
        n_cmp++;
        if (hit0 !== exp_0) begin
            n_fail++;
            $display("FAIL R8: comb hit=%0b expected %0b (in=%b)", hit0, exp_0, v);
        end
        if (r) begin
            hist.delete();
        end else begin
            hist.push_front(v);
            if (hist.size() > N) void'(hist.pop_back());
        end
    endtask

    initial begin
        logic [15:0] lfsr;
        repeat (2) @(posedge clk);
        // R2: reset state, nothing recorded
        step(1'b1, 2'b11, "R2 reset");
        step(1'b1, 2'b01, "R2 reset");
        // R7 worked sequence, R4 blanking during fill
        step(1'b0, 2'b00, "R7 R4 fill");
        step(1'b0, 2'b11, "R7 R4 fill");
        step(1'b0, 2'b01, "R7 R5 match");
        // R6: only the unconstrained delay-0 bit of input 0 differs
        step(1'b0, 2'b00, "R6 prime");
        step(1'b0, 2'b11, "R6 prime");
        step(1'b0, 2'b00, "R6 dont-care");
        // R2 R9 mid-run reset then refill
        step(1'b0, 2'b00, "R5");
        step(1'b0, 2'b11, "R5");
        step(1'b1, 2'b01, "R2 reset mid");
        step(1'b0, 2'b11, "R4 R9 refill");
        step(1'b0, 2'b01, "R4 R9 refill");
        step(1'b0, 2'b00, "R9 R5");
        step(1'b0, 2'b11, "R5");
        step(1'b0, 2'b01, "R5 R3");
        // R1 R3 R5 pseudo-random stream
        lfsr = 16'hACE1;
        for (int c = 0; c < 400; c++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(1'b0, lfsr[1:0], "R1 R3 R5 stream");
        end
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end

endmodule